// File: doc/BRIEF.md
# Single-Channel Cycle-Stealing DMA Engine

This block moves a block of words between one peripheral and system memory so that the processor does not have to copy them itself. Software sets up four things through a small register write port: the transfer direction, the peripheral address, the first memory address and the number of words. It then sets the go bit. From there the engine works alone: for every word it asks the system bus arbiter for the bus and waits for a grant. It then performs exactly one memory access, with the peripheral on the other side of that same cycle, and hands the bus straight back.

Because the bus is surrendered after every word, the processor loses at most one memory cycle per word moved. When the word count reaches zero the engine raises a level interrupt. The interrupt stays up until software writes the clear bit. Two status outputs tell software whether a block is in flight or finished.

Top module: `cs_dma_engine`

## Requirements
- R1: Register writes use `cfg_sel`. Value 0 is the control word: bit 0 starts a block, bit 1 selects the direction (0 = peripheral to memory, 1 = memory to peripheral), and bit 2 clears the interrupt and the done flag. Value 1 loads the peripheral address from the low DAW bits. Value 2 loads the start memory address. Value 3 loads the word count from the low CW bits.
- R2: In peripheral-to-memory mode, each access cycle reads `dev_rdata` from the peripheral at `dev_addr` (`dev_en`=1, `dev_we`=0) and writes it to memory (`mem_we`=1) in the same cycle. In memory-to-peripheral mode, each access cycle reads memory (`mem_we`=0) and presents `mem_rdata` to the peripheral with `dev_we`=1.
- R3: Words are moved at consecutive memory addresses from the start address upward. After each word the address rises by one and the remaining count falls by one. Memory just past the block is left untouched.
- R4: `bus_req` rises in the cycle after the go write and stays high until a grant is sampled. The single access cycle (`mem_en`=1) follows the cycle in which `bus_gnt` was sampled high.
- R5: Each bus ownership carries exactly one access. `bus_req` is low in the cycle after every access, so the bus returns to the processor between words.
- R6: A go write while the word count is zero raises `irq` and `done` in the next cycle and never raises `bus_req`.
- R7: `irq` rises in the cycle after the last word's access. It stays high until a control write with the clear bit.
- R8: After reset `busy`, `done`, `irq` and `bus_req` are low. `busy` is high from the cycle after a go write until the cycle after the last access. `done` is high from completion until the next go or clear.
- R9: All register writes, including go, are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | AW | Register write data |
| busy | output | 1 | Block in progress |
| done | output | 1 | Last block finished |
| irq | output | 1 | Completion interrupt, level |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Data to memory |
| mem_rdata | input | DW | Data from memory, same cycle |
| dev_addr | output | DAW | Peripheral address |
| dev_en | output | 1 | Peripheral access this cycle |
| dev_we | output | 1 | Peripheral write (else read) |
| dev_wdata | output | DW | Data to peripheral |
| dev_rdata | input | DW | Data from peripheral, same cycle |

## Verification
The bench builds the engine with an 8-bit address, 16-bit data, a 6-bit count and a 4-bit peripheral address. With those values a 256-word memory covers the whole address space. The 6-bit count puts the largest block of 63 words within a short run, so the full-count boundary and the one-word block are both exercised. The arbiter grants on a pseudo-random pattern and can be held off for many cycles, which shows the request waiting for a grant and the gap between words.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MOVE = 2'd2,
    ST_REST = 2'd3
  } xfer_state_e;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_DEV   = 2'd1;
  localparam logic [1:0] SEL_ADDR  = 2'd2;
  localparam logic [1:0] SEL_COUNT = 2'd3;

  localparam int BIT_GO  = 0;
  localparam int BIT_DIR = 1;
  localparam int BIT_CLR = 2;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int DAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  input  logic           busy,
  input  logic           step,
  output logic           dir_q,
  output logic [DAW-1:0] dev_q,
  output logic [AW-1:0]  addr_q,
  output logic [CW-1:0]  cnt_q,
  output logic           go,
  output logic           clr,
  output logic           cnt_zero,
  output logic           last_word
);
  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_after(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  logic wr_ok, ctrl_wr, unused_wdata;
  assign wr_ok        = cfg_we && !busy;
  assign ctrl_wr      = wr_ok && (cfg_sel == SEL_CTRL);
  assign go           = ctrl_wr && cfg_wdata[BIT_GO];
  assign clr          = ctrl_wr && cfg_wdata[BIT_CLR];
  assign cnt_zero     = (cnt_q == '0);
  assign last_word    = (cnt_q == CW'(1));
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      dev_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (step) begin
      addr_q <= addr_after(addr_q);
      cnt_q  <= cnt_after(cnt_q);
    end else if (wr_ok) begin
      case (cfg_sel)
        SEL_CTRL:  dir_q  <= cfg_wdata[BIT_DIR];
        SEL_DEV:   dev_q  <= cfg_wdata[DAW-1:0];
        SEL_ADDR:  addr_q <= cfg_wdata;
        default:   cnt_q  <= cfg_wdata[CW-1:0];
      endcase
    end
  end

  // R3: a word is never moved once the count is exhausted
  a_r3_step_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !cnt_zero);

  // R9: programmed fields are frozen while a block is running
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (dev_q == $past(dev_q)) && (dir_q == $past(dir_q)));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cnt_zero,
  input  logic last_word,
  input  logic bus_gnt,
  output logic bus_req,
  output logic access,
  output logic step,
  output logic finish,
  output logic busy
);
  xfer_state_e state, state_nx;

  logic zero_start, grant_seen, last_move;
  assign zero_start = (state == ST_IDLE) && go && cnt_zero;
  assign grant_seen = (state == ST_WAIT) && bus_gnt;
  assign last_move  = (state == ST_MOVE) && last_word;

  assign bus_req = (state == ST_WAIT) || (state == ST_MOVE);
  assign access  = (state == ST_MOVE);
  assign step    = access;
  assign finish  = zero_start || last_move;
  assign busy    = (state != ST_IDLE);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (go && !cnt_zero) state_nx = ST_WAIT;
      ST_WAIT: if (grant_seen) state_nx = ST_MOVE;
      ST_MOVE: state_nx = last_word ? ST_IDLE : ST_REST;
      default: state_nx = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // R4: an ungranted request is held
  a_r4_req_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !access && !bus_gnt) |=> bus_req);

  // R4: an access only follows a sampled grant
  a_r4_access_granted: assert property (@(posedge clk) disable iff (!rst_n)
    access |-> $past(bus_req && bus_gnt));

  // R5: one access per ownership, then the bus is released
  a_r5_one_access: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> (!access && !bus_req));

  // R6: an empty block never requests the bus
  a_r6_zero_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> !bus_req);
endmodule

// File: rtl/dma_irq.sv
module dma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic clr,
  input  logic finish,
  input  logic busy,
  output logic irq,
  output logic done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      done <= 1'b0;
    end else begin
      if (clr)       irq  <= 1'b0;
      if (go || clr) done <= 1'b0;
      if (finish) begin
        irq  <= 1'b1;
        done <= 1'b1;
      end
    end
  end

  // R7: the interrupt only falls on a clear
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);

  // R8: busy and done never show together
  a_r8_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
endmodule

// File: rtl/cs_dma_engine.sv
module cs_dma_engine #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int DAW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [AW-1:0]  cfg_wdata,
  output logic           busy,
  output logic           done,
  output logic           irq,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           mem_en,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  output logic [DAW-1:0] dev_addr,
  output logic           dev_en,
  output logic           dev_we,
  output logic [DW-1:0]  dev_wdata,
  input  logic [DW-1:0]  dev_rdata
);
  logic          dir_q, go, clr, cnt_zero, last_word;
  logic          access, step, finish;
  logic [CW-1:0] cnt_q;

  dma_regs #(.AW(AW), .CW(CW), .DAW(DAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .step(step), .dir_q(dir_q),
    .dev_q(dev_addr), .addr_q(mem_addr), .cnt_q(cnt_q), .go(go), .clr(clr),
    .cnt_zero(cnt_zero), .last_word(last_word)
  );

  dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero),
    .last_word(last_word), .bus_gnt(bus_gnt), .bus_req(bus_req),
    .access(access), .step(step), .finish(finish), .busy(busy)
  );

  dma_irq u_irq (
    .clk(clk), .rst_n(rst_n), .go(go), .clr(clr), .finish(finish),
    .busy(busy), .irq(irq), .done(done)
  );

  assign mem_en    = access;
  assign mem_we    = access && !dir_q;
  assign mem_wdata = dev_rdata;
  assign dev_en    = access;
  assign dev_we    = access && dir_q;
  assign dev_wdata = mem_rdata;

  // R2: every access moves data across, one side read and the other written
  a_r2_opposite_sides: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_we != dev_we));

  // R7: a finished block leaves the interrupt raised
  a_r7_irq_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !$past(busy) == 1'b0 && cnt_q == CW'(1)) |=> irq);
endmodule

// File: tb/sim_cs_dma_engine.sv
`timescale 1ns/1ps
module sim_cs_dma_engine;
  localparam int AW = 8, DW = 16, CW = 6, DAW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic busy, done, irq, bus_req, mem_en, mem_we, dev_en, dev_we;
  logic bus_gnt = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_wdata, dev_rdata;
  logic [DAW-1:0] dev_addr;

  always #4 clk = ~clk;

  cs_dma_engine #(.AW(AW), .DW(DW), .CW(CW), .DAW(DAW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_addr(dev_addr), .dev_en(dev_en), .dev_we(dev_we),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, req_cycles = 0, src_idx = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] sink_q [$];
  logic [7:0] lfsr = 8'h5B;
  bit hold = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // memory, peripheral and arbiter models
  assign mem_rdata = mem[mem_addr];
  assign dev_rdata = 16'hC000 + 16'(src_idx);

  always @(posedge clk) begin
    if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
    if (dev_en && !dev_we) src_idx <= src_idx + 1;
    if (dev_en && dev_we) sink_q.push_back(dev_wdata);
    if (rst_n && bus_req) req_cycles <= req_cycles + 1;
  end

  always @(posedge clk) begin
    #2;
    bus_gnt = bus_req && !hold && (lfsr[0] || lfsr[2]);
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end

  // reference model: 0 idle, 1 asking, 2 moving, 3 resting
  int m_phase = 0, m_dev = 0, m_addr = 0, m_cnt = 0;
  bit m_dir = 0, m_irq = 0, m_done = 0, m_go = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_dev = 0; m_addr = 0; m_cnt = 0;
      m_dir = 0; m_irq = 0; m_done = 0;
    end else begin
      m_go = 0;
      if (cfg_we && m_phase == 0) begin
        case (cfg_sel)
          2'd0: begin
            m_dir = cfg_wdata[1];
            if (cfg_wdata[2]) begin m_irq = 0; m_done = 0; end
            m_go = cfg_wdata[0];
          end
          2'd1: m_dev = int'(cfg_wdata) % 16;
          2'd2: m_addr = int'(cfg_wdata);
          default: m_cnt = int'(cfg_wdata) % 64;
        endcase
      end
      case (m_phase)
        0: if (m_go) begin
             m_done = 0;
             if (m_cnt == 0) begin m_irq = 1; m_done = 1; end
             else m_phase = 1;
           end
        1: if (bus_gnt) m_phase = 2;
        2: begin
             m_addr = (m_addr + 1) % 256;
             m_cnt--;
             if (m_cnt == 0) begin m_phase = 0; m_irq = 1; m_done = 1; end
             else m_phase = 3;
           end
        default: m_phase = 1;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(bus_req === (m_phase == 1 || m_phase == 2), "R4 bus_req", bus_req, (m_phase == 1 || m_phase == 2));
      chk(mem_en === (m_phase == 2), "R5 mem_en", mem_en, (m_phase == 2));
      chk(busy === (m_phase != 0), "R8 busy", busy, (m_phase != 0));
      chk(done === m_done, "R8 done", done, m_done);
      chk(irq === m_irq, "R7 irq", irq, m_irq);
      if (m_phase == 2) begin
        chk(int'(mem_addr) == m_addr, "R3 mem_addr", mem_addr, m_addr);
        chk(mem_we === !m_dir, "R2 mem_we", mem_we, !m_dir);
        chk(dev_we === m_dir, "R2 dev_we", dev_we, m_dir);
        chk(int'(dev_addr) == m_dev, "R1 dev_addr", dev_addr, m_dev);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input int sel, input int data);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = AW'(data);
    @(posedge clk); #2;
    cfg_we = 1'b0;
  endtask

  task automatic start_block(input bit dir, input int dev, input int addr, input int n);
    wr(1, dev); wr(2, addr); wr(3, n);
    wr(0, 5 | (int'(dir) << 1));   // R1: go + clear + direction
  endtask

  task automatic wait_irq();
    @(negedge clk);
    while (!irq) @(negedge clk);
  endtask

  task automatic in_block(input int dev, input int addr, input int n, input string tag);
    int base;
    logic [DW-1:0] after;
    base  = src_idx;
    after = mem[(addr + n) % 256];
    start_block(1'b0, dev, addr, n);
    wait_irq();
    for (int i = 0; i < n; i++)
      chk(mem[(addr + i) % 256] == 16'hC000 + 16'(base + i), tag,
          mem[(addr + i) % 256], 16'hC000 + 16'(base + i));
    chk(mem[(addr + n) % 256] == after, "R3 neighbour untouched", mem[(addr + n) % 256], after);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7 + 1);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !irq && !bus_req, "R8 reset state",
        {busy, done, irq, bus_req}, 0);

    // R2 R3: peripheral to memory, five words
    in_block(3, 8'h10, 5, "R2 in-block data");
    chk(irq == 1'b1, "R7 irq held", irq, 1);
    repeat (4) @(negedge clk);
    chk(irq == 1'b1, "R7 irq still held", irq, 1);
    wr(0, 4);
    @(negedge clk);
    chk(irq == 1'b0 && done == 1'b0, "R7 clear drops irq", irq, 0);

    // R2: memory to peripheral from the same five words
    begin
      logic [DW-1:0] want [5];
      for (int i = 0; i < 5; i++) want[i] = mem[8'h10 + i];
      sink_q.delete();
      start_block(1'b1, 9, 8'h10, 5);
      wait_irq();
      chk(sink_q.size() == 5, "R2 out-block length", sink_q.size(), 5);
      for (int i = 0; i < 5 && i < sink_q.size(); i++)
        chk(sink_q[i] == want[i], "R2 out-block data", sink_q[i], want[i]);
    end

    // R4: grant withheld, the request waits
    hold = 1'b1;
    start_block(1'b0, 1, 8'h30, 3);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(bus_req == 1'b1 && mem_en == 1'b0, "R4 request held without grant", bus_req, 1);
    end
    hold = 1'b0;
    wait_irq();

    // R6: empty block
    begin
      int r0;
      wr(3, 0);
      r0 = req_cycles;
      wr(0, 5);
      @(negedge clk);
      chk(irq == 1'b1 && done == 1'b1, "R6 empty block completes", irq, 1);
      repeat (3) @(negedge clk);
      chk(req_cycles == r0, "R6 no bus request", req_cycles - r0, 0);
    end

    // R9: writes during a block are ignored
    begin
      logic [DW-1:0] keep;
      int r0;
      keep = mem[8'h80];
      start_block(1'b0, 2, 8'h40, 4);
      wr(2, 8'h80); wr(3, 9); wr(1, 7); wr(0, 3);
      wait_irq();
      chk(mem[8'h80] == keep, "R9 address write ignored", mem[8'h80], keep);
      r0 = req_cycles;
      wr(0, 5);   // no count written: count must still be zero
      repeat (4) @(negedge clk);
      chk(req_cycles == r0 && irq == 1'b1, "R9 count write ignored", req_cycles - r0, 0);
    end

    // R3: largest count, then a single word
    in_block(5, 8'hA0, 63, "R3 full-count block");
    in_block(6, 8'h08, 1, "R3 one-word block");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule